// File: doc/BRIEF.md
# UART FIFO control and status

This block sits between a CPU register interface and the serial engines of a UART. It holds the transmit and receive queues and keeps the transmit-side status bits up to date. It interprets writes to a write-only FIFO control byte, accepts characters from the CPU for transmission, hands them one at a time to an external transmit shift register, and stores received characters together with an error tag. A per-queue error tally drives the error-in-FIFO status bit, and a transmit-empty interrupt request follows the holding-empty flag.

With the enable bit clear, the block behaves as a single holding register on each side. With it set, each side becomes a queue of `DEPTH` entries. Any change of mode empties both queues. The external shift register reports `tsr_idle` when it holds nothing and its last bit has left the line. It must drop `tsr_idle` on the clock edge at which it takes a character.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the block is in unbuffered mode, with the DMA select and the trigger field at 0, both queues empty, `lsr_thre` at 1, `lsr_fifo_err` at 0, `thre_irq` at 0 and `rbr_rdata` at 0.
- R2: On a control write with bit 0 at 1, bit 0 sets the queue mode, bit 3 is copied to `dma_mode` and bits 7:6 are copied to `rx_trig`. On a control write with bit 0 at 0, bits 1, 2, 3, 6 and 7 have no effect. Bits 4 and 5 are always ignored.
- R3: A control write whose bit 0 differs from the current mode empties both queues in the same edge.
- R4: A control write with bits 0 and 1 at 1 empties the receive queue and clears its error tally. A control write with bits 0 and 2 at 1 empties the transmit queue. Neither affects a character already in the shift register (`tsr_idle` and `lsr_temt` stay low).
- R5: In unbuffered mode the transmit side holds one character. `lsr_thre` falls after a CPU write and rises once the character moves to the shift register. A write while it is occupied is dropped.
- R6: In queue mode `lsr_thre` is 1 exactly when the transmit queue is empty. The queue holds up to `DEPTH` characters, and a write to a full queue is dropped.
- R7: `tx_load` is 1 exactly when the transmit side holds a character and `tsr_idle` is 1. `tx_data` is then the oldest character, and characters leave in write order.
- R8: `lsr_temt` is 1 exactly when the transmit side is empty and `tsr_idle` is 1. No status read exists that could clear it or `lsr_thre`.
- R9: A pending transmit-empty request is set on the edge after `lsr_thre` rises, or after `ier_thre_en` rises while `lsr_thre` is 1. It is cleared by `iir_rd_thre` or `thr_wr`, and a clear wins over a set. `thre_irq` is the pending request gated by `ier_thre_en`.
- R10: `lsr_fifo_err` is 0 in unbuffered mode. In queue mode it is 1 while any stored receive entry was pushed with `rx_err` at 1.
- R11: In queue mode `rx_level_hit` is 1 when the receive count is at least 1, 4, 8 or 14 for `rx_trig` values 00, 01, 10 and 11. In unbuffered mode it equals `rx_ready`.
- R12: A read with `rbr_rd` of a non-empty receive side puts the oldest character on `rbr_rdata` one edge later. A read of an empty receive side keeps `rbr_rdata` unchanged. A push to a full receive side (one entry in unbuffered mode) is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the FIFO control byte |
| ctl_wdata | input | 8 | FIFO control byte |
| thr_wr | input | 1 | CPU write to the transmit holding location |
| thr_wdata | input | DATA_W | Character to transmit |
| rbr_rd | input | 1 | CPU read of the receive data location |
| rbr_rdata | output | DATA_W | Last character read from the receive side |
| iir_rd_thre | input | 1 | Identification read that reports the transmit-empty source |
| ier_thre_en | input | 1 | Transmit-empty interrupt enable |
| tsr_idle | input | 1 | Shift register empty and line quiet |
| tx_load | output | 1 | Character handed to the shift register this cycle |
| tx_data | output | DATA_W | Character being handed over |
| rx_push | input | 1 | Receiver delivers a character |
| rx_data | input | DATA_W | Received character |
| rx_err | input | 1 | Parity, framing or break seen on this character |
| lsr_thre | output | 1 | Transmit holding side empty |
| lsr_temt | output | 1 | Transmitter fully empty |
| lsr_fifo_err | output | 1 | Error-tagged entry present in the receive queue |
| rx_ready | output | 1 | Receive side holds data |
| rx_level_hit | output | 1 | Receive count at or above the trigger threshold |
| thre_irq | output | 1 | Transmit-empty interrupt request |
| fifo_mode | output | 1 | Queue mode active |
| dma_mode | output | 1 | DMA signalling mode select |
| rx_trig | output | 2 | Receive trigger field |

## Verification
The bench builds the block with `DATA_W` = 8 and `DEPTH` = 16, and pairs it with a behavioural shift register that stays busy for five cycles per character. The depth of 16 lets a write burst run past capacity and lets the receive count reach the 14-entry threshold. The slow shift register keeps the queue non-empty long enough that `lsr_thre` and `lsr_temt` separate, and that flushes and mode changes land while a character is still on the line.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam int unsigned CHAR_W = 8;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } rx_trig_e;

  typedef struct packed {
    logic              err;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  // Receive threshold in bytes for each trigger code.
  function automatic int unsigned trig_bytes(input rx_trig_e code);
    case (code)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/ufc_sync_fifo.sv
module ufc_sync_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          one_deep,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign empty = (cnt_q == '0);
  assign full  = one_deep ? !empty : (cnt_q == CW'(DEPTH));
  assign count = cnt_q;
  assign dout  = mem[rd_q];

  always_comb begin
    push_ok = push && !full;
    pop_ok  = pop && !empty;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_q] <= din;
  end

  p_cap_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_flush_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  p_full_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> $stable(cnt_q));
  p_empty_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/ufc_err_tally.sv
module ufc_err_tally #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] tally
);

  logic [CW-1:0] tally_q, tally_d;

  always_comb begin
    tally_d = tally_q;
    if (clr)              tally_d = '0;
    else if (inc && !dec) tally_d = tally_q + 1'b1;
    else if (dec && !inc) tally_d = tally_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tally_q <= '0;
    else        tally_q <= tally_d;
  end

  assign tally = tally_q;

  p_tally_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tally_q == '0));

endmodule

// File: rtl/ufc_thre_irq.sv
module ufc_thre_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic thre,
  input  logic enable,
  input  logic clr_rd,
  input  logic clr_wr,
  output logic irq
);

  logic pend_q, pend_d;
  logic thre_q, en_q;
  logic set_evt;

  always_comb begin
    set_evt = (thre && !thre_q) || (enable && !en_q && thre);
    pend_d  = pend_q;
    if (clr_rd || clr_wr) pend_d = 1'b0;
    else if (set_evt)     pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      thre_q <= 1'b1;
      en_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      thre_q <= thre;
      en_q   <= enable;
    end
  end

  assign irq = pend_q && enable;

  p_id_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd |=> !pend_q);
  p_no_irq_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !irq);

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = CHAR_W,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned RX_W  = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic              thr_wr,
  input  logic [DATA_W-1:0] thr_wdata,
  input  logic              rbr_rd,
  output logic [DATA_W-1:0] rbr_rdata,
  input  logic              iir_rd_thre,
  input  logic              ier_thre_en,
  input  logic              tsr_idle,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_err,
  output logic              lsr_thre,
  output logic              lsr_temt,
  output logic              lsr_fifo_err,
  output logic              rx_ready,
  output logic              rx_level_hit,
  output logic              thre_irq,
  output logic              fifo_mode,
  output logic              dma_mode,
  output logic [1:0]        rx_trig
);

  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_RXCLR = 1;
  localparam int unsigned B_TXCLR = 2;
  localparam int unsigned B_DMA   = 3;
  localparam int unsigned B_TRIG  = 6;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // Control byte.
  logic       fen_q, fen_d, dma_q, dma_d;
  rx_trig_e   trig_q, trig_d;
  logic       mode_flip, rx_flush, tx_flush;
  logic       unused_ctl_bits;
  assign unused_ctl_bits = ^ctl_wdata[5:4];

  always_comb begin
    fen_d     = fen_q;
    dma_d     = dma_q;
    trig_d    = trig_q;
    mode_flip = ctl_wr && (ctl_wdata[B_EN] != fen_q);
    rx_flush  = mode_flip || (ctl_wr && ctl_wdata[B_EN] && ctl_wdata[B_RXCLR]);
    tx_flush  = mode_flip || (ctl_wr && ctl_wdata[B_EN] && ctl_wdata[B_TXCLR]);
    if (ctl_wr) begin
      fen_d = ctl_wdata[B_EN];
      if (ctl_wdata[B_EN]) begin
        dma_d  = ctl_wdata[B_DMA];
        trig_d = rx_trig_e'(ctl_wdata[B_TRIG +: 2]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      fen_q  <= 1'b0;
      dma_q  <= 1'b0;
      trig_q <= TRIG_1;
    end else begin
      fen_q  <= fen_d;
      dma_q  <= dma_d;
      trig_q <= trig_d;
    end
  end

  // Transmit side.
  logic [CW-1:0] tx_count;
  logic          tx_empty, tx_full, tx_push_ok, tx_pop_ok;

  ufc_sync_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_core_n), .one_deep(!fen_q), .flush(tx_flush),
    .push(thr_wr), .din(thr_wdata), .pop(tx_load), .dout(tx_data),
    .count(tx_count), .empty(tx_empty), .full(tx_full),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  assign tx_load  = !tx_empty && tsr_idle;
  assign lsr_thre = tx_empty;
  assign lsr_temt = tx_empty && tsr_idle;

  // Receive side.
  rx_entry_t     rx_head;
  logic [CW-1:0] rx_count, err_tally;
  logic          rx_empty, rx_full, rx_push_ok, rx_pop_ok;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  ufc_sync_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_core_n), .one_deep(!fen_q), .flush(rx_flush),
    .push(rx_push), .din({rx_err, rx_data}), .pop(rbr_rd), .dout(rx_head),
    .count(rx_count), .empty(rx_empty), .full(rx_full),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  ufc_err_tally #(.CW(CW)) u_err_tally (
    .clk(clk), .rst_n(rst_core_n), .clr(rx_flush),
    .inc(rx_push_ok && rx_err), .dec(rx_pop_ok && rx_head.err),
    .tally(err_tally)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (rx_pop_ok) rdata_d = rx_head.data;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign rbr_rdata    = rdata_q;
  assign rx_ready     = !rx_empty;
  assign lsr_fifo_err = fen_q && (err_tally != '0);
  assign rx_level_hit = fen_q ? (rx_count >= CW'(trig_bytes(trig_q))) : !rx_empty;

  ufc_thre_irq u_thre_irq (
    .clk(clk), .rst_n(rst_core_n), .thre(lsr_thre), .enable(ier_thre_en),
    .clr_rd(iir_rd_thre), .clr_wr(thr_wr), .irq(thre_irq)
  );

  assign fifo_mode = fen_q;
  assign dma_mode  = dma_q;
  assign rx_trig   = trig_q;

  p_temt_needs_thre_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    lsr_temt |-> lsr_thre);
  p_load_needs_idle_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_load |-> tsr_idle);
  p_err_bit_unbuf_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    !fifo_mode |-> !lsr_fifo_err);
  p_tally_bound_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    err_tally <= rx_count);
  p_ctl_ignored_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ctl_wr && !ctl_wdata[B_EN] && !fifo_mode) |=> ($stable(dma_mode) && $stable(rx_trig)));
  p_empty_read_holds_r12: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rbr_rd && !rx_ready) |=> $stable(rbr_rdata));
  p_unbuf_one_deep_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !fifo_mode |-> (tx_count <= 1 && rx_count <= 1));

endmodule

// File: tb/uart_fifo_ctl_tb.sv
module uart_fifo_ctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int DEPTH      = 16;
  localparam int TSR_LEN    = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctl_wr, thr_wr, rbr_rd, iir_rd_thre, ier_thre_en, rx_push, rx_err;
  logic [7:0]    ctl_wdata;
  logic [DW-1:0] thr_wdata, rx_data, rbr_rdata, tx_data;
  logic          tsr_idle, tx_load, lsr_thre, lsr_temt, lsr_fifo_err;
  logic          rx_ready, rx_level_hit, thre_irq, fifo_mode, dma_mode;
  logic [1:0]    rx_trig;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_fifo_ctl #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata), .rbr_rd(rbr_rd), .rbr_rdata(rbr_rdata),
    .iir_rd_thre(iir_rd_thre), .ier_thre_en(ier_thre_en), .tsr_idle(tsr_idle),
    .tx_load(tx_load), .tx_data(tx_data), .rx_push(rx_push), .rx_data(rx_data),
    .rx_err(rx_err), .lsr_thre(lsr_thre), .lsr_temt(lsr_temt),
    .lsr_fifo_err(lsr_fifo_err), .rx_ready(rx_ready), .rx_level_hit(rx_level_hit),
    .thre_irq(thre_irq), .fifo_mode(fifo_mode), .dma_mode(dma_mode), .rx_trig(rx_trig)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural shift register: busy for TSR_LEN cycles per character.
  int tsr_cnt = 0;
  assign tsr_idle = (tsr_cnt == 0);

  // Reference model state.
  int  mq_tx[$];
  int  mq_rx[$];
  bit  m_fen, m_dma, m_pend, m_thre_q, m_ier_q;
  int  m_trig, m_rdata;

  function automatic int m_lvl();
    case (m_trig)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic bit m_any_err();
    foreach (mq_rx[i]) if (mq_rx[i] >= 256) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq_tx.delete(); mq_rx.delete();
      m_fen = 0; m_dma = 0; m_trig = 0; m_pend = 0; m_thre_q = 1; m_ier_q = 0; m_rdata = 0;
      tsr_cnt <= 0;
    end else begin
      bit thre_now, load, txfull, rxfull, rxempty, ftx, frx, setv, clrv;
      int cap;
      thre_now = (mq_tx.size() == 0);
      load     = !thre_now && (tsr_cnt == 0);
      cap      = m_fen ? DEPTH : 1;
      txfull   = mq_tx.size() >= cap;
      rxfull   = mq_rx.size() >= cap;
      rxempty  = mq_rx.size() == 0;
      ftx = 0; frx = 0;
      if (ctl_wr) begin
        if (ctl_wdata[0] != m_fen) begin ftx = 1; frx = 1; end
        if (ctl_wdata[0] && ctl_wdata[1]) frx = 1;
        if (ctl_wdata[0] && ctl_wdata[2]) ftx = 1;
      end
      if (rbr_rd && !rxempty) m_rdata = mq_rx[0] % 256;
      if (ftx) mq_tx.delete();
      else begin
        if (load) void'(mq_tx.pop_front());
        if (thr_wr && !txfull) mq_tx.push_back(int'(thr_wdata));
      end
      if (frx) mq_rx.delete();
      else begin
        if (rbr_rd && !rxempty) void'(mq_rx.pop_front());
        if (rx_push && !rxfull) mq_rx.push_back(int'(rx_data) + (rx_err ? 256 : 0));
      end
      setv = (thre_now && !m_thre_q) || (ier_thre_en && !m_ier_q && thre_now);
      clrv = iir_rd_thre || thr_wr;
      if (clrv) m_pend = 0; else if (setv) m_pend = 1;
      m_thre_q = thre_now;
      m_ier_q  = ier_thre_en;
      if (ctl_wr) begin
        if (ctl_wdata[0]) begin m_dma = ctl_wdata[3]; m_trig = int'(ctl_wdata[7:6]); end
        m_fen = ctl_wdata[0];
      end
      tsr_cnt <= load ? TSR_LEN : ((tsr_cnt > 0) ? tsr_cnt - 1 : 0);
    end
  end

  // Compare against the model in the middle of every cycle.
  always @(negedge clk) begin
    if (cmp_on) begin
      bit  mthre, mload;
      int  lvl;
      mthre = (mq_tx.size() == 0);
      mload = !mthre && tsr_idle;
      lvl   = m_fen ? m_lvl() : 1;
      chk(m_fen ? "R6" : "R5", "lsr_thre", int'(lsr_thre), int'(mthre));
      chk("R8", "lsr_temt", int'(lsr_temt), int'(mthre && tsr_idle));
      chk("R7", "tx_load", int'(tx_load), int'(mload));
      if (mload) chk("R7", "tx_data", int'(tx_data), mq_tx[0]);
      chk("R10", "lsr_fifo_err", int'(lsr_fifo_err), int'(m_fen && m_any_err()));
      chk("R11", "rx_level_hit", int'(rx_level_hit), int'(mq_rx.size() >= lvl));
      chk("R12", "rx_ready", int'(rx_ready), int'(mq_rx.size() != 0));
      chk("R12", "rbr_rdata", int'(rbr_rdata), m_rdata);
      chk("R9", "thre_irq", int'(thre_irq), int'(m_pend && ier_thre_en));
      chk("R2", "fifo_mode", int'(fifo_mode), int'(m_fen));
      chk("R2", "dma_mode", int'(dma_mode), int'(m_dma));
      chk("R2", "rx_trig", int'(rx_trig), m_trig);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic clear_strobes();
    ctl_wr = 0; thr_wr = 0; rbr_rd = 0; iir_rd_thre = 0; rx_push = 0;
  endtask

  task automatic fcr(input logic [7:0] d);
    @(negedge clk); #1; ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); #1; clear_strobes();
  endtask

  task automatic wr_thr(input logic [7:0] d);
    @(negedge clk); #1; thr_wr = 1; thr_wdata = d;
    @(negedge clk); #1; clear_strobes();
  endtask

  task automatic rx_in(input logic [7:0] d, input logic e);
    @(negedge clk); #1; rx_push = 1; rx_data = d; rx_err = e;
    @(negedge clk); #1; clear_strobes();
  endtask

  task automatic rd_rbr();
    @(negedge clk); #1; rbr_rd = 1;
    @(negedge clk); #1; clear_strobes();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ier_thre_en = 0; ctl_wdata = 0; thr_wdata = 0; rx_data = 0; rx_err = 0;
    clear_strobes();
    step(4);
    rst_n = 1;
    step(4);
    // R1: reset state
    chk("R1", "fifo_mode", int'(fifo_mode), 0);
    chk("R1", "lsr_thre", int'(lsr_thre), 1);
    chk("R1", "lsr_fifo_err", int'(lsr_fifo_err), 0);
    chk("R1", "thre_irq", int'(thre_irq), 0);
    chk("R1", "rbr_rdata", int'(rbr_rdata), 0);
    cmp_on = 1;

    // R5: unbuffered holding register, back-to-back writes
    ier_thre_en = 1;
    step(2);
    wr_thr(8'h41); wr_thr(8'h42); wr_thr(8'h43);
    step(20);
    @(negedge clk); #1; iir_rd_thre = 1; @(negedge clk); #1; clear_strobes();
    chk("R9", "thre_irq after id read", int'(thre_irq), 0);

    // R2: control write with bit 0 clear is ignored
    fcr(8'hCE);
    chk("R2", "dma ignored", int'(dma_mode), 0);
    chk("R2", "trig ignored", int'(rx_trig), 0);

    // R12, R10: unbuffered receive, one deep, error bit hidden
    rx_in(8'h11, 1); rx_in(8'h22, 0);
    chk("R10", "err hidden unbuffered", int'(lsr_fifo_err), 0);
    rd_rbr(); rd_rbr();
    chk("R12", "empty read holds", int'(rbr_rdata), 8'h11);

    // R3: enable queue mode with trigger 14, DMA mode 1
    fcr(8'hC9);
    chk("R3", "mode switch empties rx", int'(rx_ready), 0);
    for (int i = 0; i < 20; i++) wr_thr(8'h60 + 8'(i));
    for (int i = 0; i < 18; i++) rx_in(8'h80 + 8'(i), 1'(i == 3));
    chk("R11", "level 14 reached", int'(rx_level_hit), 1);
    chk("R10", "err flagged", int'(lsr_fifo_err), 1);
    for (int i = 0; i < 4; i++) rd_rbr();
    chk("R10", "err cleared after pop", int'(lsr_fifo_err), 0);
    rx_in(8'h99, 1);
    // R4: receive flush clears tally; transmit flush while shifting
    fcr(8'h43);
    chk("R4", "rx flushed", int'(rx_ready), 0);
    chk("R4", "tally cleared", int'(lsr_fifo_err), 0);
    step(1);
    fcr(8'h05);
    chk("R4", "tx flushed", int'(lsr_thre), 1);
    chk("R4", "shift reg untouched", int'(lsr_temt), int'(tsr_idle));
    step(10);
    // R11: other thresholds
    fcr(8'h41);
    for (int i = 0; i < 5; i++) rx_in(8'h30 + 8'(i), 0);
    fcr(8'h81);
    for (int i = 0; i < 4; i++) rx_in(8'h40 + 8'(i), 0);
    fcr(8'h01);
    chk("R11", "trigger 1", int'(rx_level_hit), 1);
    // R3: back to unbuffered empties both sides
    wr_thr(8'h77); wr_thr(8'h78);
    fcr(8'h00);
    chk("R3", "rx emptied", int'(rx_ready), 0);
    chk("R3", "tx emptied", int'(lsr_thre), 1);

    // Mixed traffic compared against the model every cycle.
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      clear_strobes();
      thr_wr      = ($urandom_range(0, 3) == 0);
      thr_wdata   = 8'($urandom);
      rx_push     = ($urandom_range(0, 2) == 0);
      rx_data     = 8'($urandom);
      rx_err      = ($urandom_range(0, 5) == 0);
      rbr_rd      = ($urandom_range(0, 3) == 0);
      iir_rd_thre = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 99) == 0) ier_thre_en = ~ier_thre_en;
      if ($urandom_range(0, 149) == 0) begin
        ctl_wr = 1; ctl_wdata = 8'($urandom);
      end
    end
    @(negedge clk); #1; clear_strobes();
    step(40);
    cmp_on = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule